// File: doc/BRIEF.md
# Coherence Line Controller with Reservation

This block holds the coherence state of one L1 cache line under a five-state MOESI-style protocol: Idle, Shared, Owned, Modified, and Modified with local writes. It takes local core requests (load, instruction fetch, store, flush), snoop requests from other agents, and demotion requests that push the line out to the L2. It drives the outbound GETS, GETX and GETF request strobes, the load and store hit strobes, and the current access permission.

When a line is moved from the L2 back into the L1, the block passes through a transfer state. When the transfer completes, it enters a reserved variant of the matching stable state. A reserved line grants the same permission as its base state. It accepts local requests, but it holds snoops and demotions back without consuming them. A local request is therefore always served first, and the core cannot be starved by a stream of snoops that arrive right after the line comes back. The first local access returns the line to a normal state, and any snoop that was held is then accepted.

Outstanding requests wait for data and for a count of acknowledgements. The count is set by a parameter for the number of peer agents. An upgrade from Owned or from Modified expects one acknowledgement fewer.

Top module: `coh_line_ctrl`

## Requirements
- R1: A transfer start in a plain stable state moves the line to the matching transfer state. A transfer completion in a transfer state moves the line to the matching reserved state, not to the plain stable state.
- R2: `perm` encodes 0 = none, 1 = read-only, 2 = read-write, 3 = busy. Reserved and plain states grant the same permission: Idle 0, Shared/Owned/Modified 1, locally-dirty 2. Transfer states and pending-from-Idle states are 3. Upgrades and flushes pending from a valid copy are 1.
- R3: In a reserved state every snoop is held: `snp_ready` stays low and the line is unchanged, while local requests are still served.
- R4: In a transfer state, snoops, demotions and all local requests, including a flush, are held.
- R5: A demotion is held in reserved, transfer and pending states. In a plain stable state it is accepted and leaves the line state unchanged.
- R6: A load (op 0) or fetch (op 1) in reserved Shared, Owned, Modified or locally-dirty pulses `ld_hit` and returns the line to the plain state with the same name.
- R7: A store (op 2) in reserved or plain Modified, or in reserved or plain locally-dirty, pulses `st_hit` and leaves the line locally-dirty.
- R8: Reserved Idle behaves like Idle. A load or fetch pulses `gets`, a store pulses `getx`, and a flush (op 3) pulses `getf`, in each case with busy permission. A flush from Modified or locally-dirty pulses `getf`. A pending read ends in Shared, or in Modified if the data is exclusive. A pending flush ends in Idle.
- R9: A store in Shared pulses `getx` and needs NUM_ACKS acknowledgements. A store in Owned needs NUM_ACKS-1. The line becomes locally-dirty one cycle after the last acknowledgement and the data are both present, and not before.
- R10: Ports are served at most one per cycle in the priority order snoop, then demotion, then local request. A held port is skipped so that a lower one can be served. In a cycle where a transfer start, a transfer completion or a request completion applies, no port is ready.
- R11: A snoop held in a reserved state is accepted in the first cycle after the line leaves that state, exactly once.
- R12: In plain stable states, an exclusive request (snoop op 0) or an invalidate (op 5) sends the line to Idle. Shared, merged-shared and shared-no-migrate requests (ops 1, 2, 3) take Modified or locally-dirty to Owned. A DMA read (op 4) changes nothing. In pending states snoops are accepted with no state change.
- R13: After reset the line is Idle, `perm` is 0, all strobes are low, and the snoop and local ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local op: 0 load, 1 fetch, 2 store, 3 flush |
| req_ready | output | 1 | Local request accepted this cycle |
| snp_valid | input | 1 | Snoop present |
| snp_op | input | 3 | Snoop op: 0 exclusive, 1 shared, 2 merged, 3 no-migrate, 4 DMA read, 5 invalidate |
| snp_ready | output | 1 | Snoop accepted this cycle |
| xfer_start | input | 1 | L2-to-L1 transfer begins |
| xfer_done | input | 1 | L2-to-L1 transfer completes |
| dem_valid | input | 1 | L1-to-L2 demotion request |
| dem_ready | output | 1 | Demotion accepted this cycle |
| ack_in | input | 1 | One acknowledgement for the outstanding request |
| fill_in | input | 1 | Data for the outstanding request arrived |
| fill_excl | input | 1 | Arrived data is exclusive |
| gets | output | 1 | Shared request strobe |
| getx | output | 1 | Exclusive request strobe |
| getf | output | 1 | Flush request strobe |
| ld_hit | output | 1 | Load or fetch hit strobe |
| st_hit | output | 1 | Store hit strobe |
| perm | output | 2 | Current access permission |

## Verification
The hardest situation to reach is a snoop that waits through a reserved state and is then taken in exactly the cycle after a local access releases the line. Reaching it needs a full sequence: fill the line, start and complete a transfer, and only then raise the snoop. The snoop is kept asserted while the local request is issued alongside it. The bench counts every snoop handshake at the clock edge. It checks that the count stays flat while the line is reserved and rises by one right after release. A transfer start that arrives together with a pending snoop covers the case where a completion cycle blocks every port.

// File: rtl/coh_line_pkg.sv
// Shared types for the coherence line controller.
// Assumes one line per instance; state encodings are private to the block.
package coh_line_pkg;

    typedef enum logic [4:0] {
        LN_INV, LN_SHR, LN_OWN, LN_MOD, LN_DRT,
        RSV_INV, RSV_SHR, RSV_OWN, RSV_MOD, RSV_DRT,
        XFR_INV, XFR_SHR, XFR_OWN, XFR_MOD, XFR_DRT,
        PND_RDS, PND_WR_I, PND_WR_S, PND_WR_O,
        PND_FL_I, PND_FL_S, PND_FL_O, PND_FL_M
    } line_st_t;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_BUSY = 2'd3
    } perm_t;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_FETCH = 2'd1;
    localparam logic [1:0] OP_STORE = 2'd2;
    localparam logic [1:0] OP_FLUSH = 2'd3;

    localparam logic [2:0] SNP_EXCL  = 3'd0;
    localparam logic [2:0] SNP_SHR   = 3'd1;
    localparam logic [2:0] SNP_MRG   = 3'd2;
    localparam logic [2:0] SNP_NOMIG = 3'd3;
    localparam logic [2:0] SNP_DMA   = 3'd4;
    localparam logic [2:0] SNP_INV   = 3'd5;

    // Port indices in descending priority
    localparam int PORT_SNP  = 0;
    localparam int PORT_DEM  = 1;
    localparam int PORT_REQ  = 2;
    localparam int NUM_PORTS = 3;

    // Plain stable state behind a plain or reserved state
    function automatic line_st_t base_of(input line_st_t s);
        case (s)
            LN_SHR, RSV_SHR: base_of = LN_SHR;
            LN_OWN, RSV_OWN: base_of = LN_OWN;
            LN_MOD, RSV_MOD: base_of = LN_MOD;
            LN_DRT, RSV_DRT: base_of = LN_DRT;
            default:         base_of = LN_INV;
        endcase
    endfunction

    // Transfer state entered from a plain stable state
    function automatic line_st_t to_xfr(input line_st_t s);
        case (s)
            LN_SHR:  to_xfr = XFR_SHR;
            LN_OWN:  to_xfr = XFR_OWN;
            LN_MOD:  to_xfr = XFR_MOD;
            LN_DRT:  to_xfr = XFR_DRT;
            default: to_xfr = XFR_INV;
        endcase
    endfunction

    // Reserved state entered when a transfer completes
    function automatic line_st_t to_rsv(input line_st_t s);
        case (s)
            XFR_SHR: to_rsv = RSV_SHR;
            XFR_OWN: to_rsv = RSV_OWN;
            XFR_MOD: to_rsv = RSV_MOD;
            XFR_DRT: to_rsv = RSV_DRT;
            default: to_rsv = RSV_INV;
        endcase
    endfunction

endpackage

// File: rtl/coh_line_class.sv
// Classifies the line state into groups and decodes the access permission.
// Purely combinational; assumes every state belongs to exactly one group.
module coh_line_class
    import coh_line_pkg::*;
(
    input  line_st_t st,
    output logic     is_plain,
    output logic     is_rsv,
    output logic     is_xfr,
    output logic     is_pend,
    output perm_t    perm
);

    // Group membership
    always_comb begin
        is_plain = 1'b0;
        is_rsv   = 1'b0;
        is_xfr   = 1'b0;
        is_pend  = 1'b0;
        case (st)
            LN_INV, LN_SHR, LN_OWN, LN_MOD, LN_DRT:      is_plain = 1'b1;
            RSV_INV, RSV_SHR, RSV_OWN, RSV_MOD, RSV_DRT: is_rsv   = 1'b1;
            XFR_INV, XFR_SHR, XFR_OWN, XFR_MOD, XFR_DRT: is_xfr   = 1'b1;
            default:                                     is_pend  = 1'b1;
        endcase
    end

    // Permission: reserved states mirror their base state
    always_comb begin
        case (st)
            LN_INV, RSV_INV:                     perm = PERM_NONE;
            LN_SHR, RSV_SHR, LN_OWN, RSV_OWN,
            LN_MOD, RSV_MOD:                     perm = PERM_RD;
            LN_DRT, RSV_DRT:                     perm = PERM_RW;
            PND_WR_S, PND_WR_O, PND_FL_S,
            PND_FL_O, PND_FL_M:                  perm = PERM_RD;
            default:                             perm = PERM_BUSY;
        endcase
    end

endmodule

// File: rtl/coh_line_arb.sv
// Fixed-priority arbiter: index 0 wins. A port that is stalled is skipped,
// so a lower port can be served in the same cycle. A block input holds
// every port. Assumes the caller turns valid & ready into the handshake.
module coh_line_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] valid,
    input  logic [N-1:0] stall,
    input  logic         block,
    output logic [N-1:0] ready
);

    // Ready goes to a port when no servable higher port is valid
    always_comb begin
        logic taken;
        taken = block;
        for (int i = 0; i < N; i++) begin
            ready[i] = !taken && !stall[i];
            if (valid[i] && !stall[i]) taken = 1'b1;
        end
    end

endmodule

// File: rtl/coh_line_ackcnt.sv
// Tracks the completion of an outstanding request. It holds the number of
// acknowledgements still expected, whether data is present, and whether
// that data was exclusive. Assumes ack and fill arrive only while pending.
module coh_line_ackcnt #(
    parameter int NUM_ACKS = 3,
    localparam int CW = $clog2(NUM_ACKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic          load_have,
    input  logic          ack,
    input  logic          fill,
    input  logic          fill_excl,
    output logic          all_done,
    output logic          excl
);

    logic [CW-1:0] cnt_q;
    logic          have_q;

    // Count, data flag and exclusivity of the outstanding request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            have_q <= 1'b0;
            excl   <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_cnt;
            have_q <= load_have;
            excl   <= 1'b0;
        end else begin
            if (ack && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (fill) begin
                have_q <= 1'b1;
                excl   <= fill_excl;
            end
        end
    end

    // Request is finished once data is here and no acks remain
    always_comb all_done = have_q && (cnt_q == '0);

endmodule

// File: rtl/coh_line_ctrl.sv
// Per-line L1 coherence controller with reserved states after an L2-to-L1
// transfer. While reserved, snoops and demotions are held and the local
// request port is served first. Assumes the line is allocated externally
// and that transfer, ack and fill inputs are single-cycle pulses.
module coh_line_ctrl #(
    parameter int NUM_ACKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    output logic       req_ready,
    input  logic       snp_valid,
    input  logic [2:0] snp_op,
    output logic       snp_ready,
    input  logic       xfer_start,
    input  logic       xfer_done,
    input  logic       dem_valid,
    output logic       dem_ready,
    input  logic       ack_in,
    input  logic       fill_in,
    input  logic       fill_excl,
    output logic       gets,
    output logic       getx,
    output logic       getf,
    output logic       ld_hit,
    output logic       st_hit,
    output logic [1:0] perm
);
    import coh_line_pkg::*;

    localparam int CW = $clog2(NUM_ACKS + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(NUM_ACKS);
    localparam logic [CW-1:0] CNT_LESS = CW'(NUM_ACKS - 1);

    line_st_t st_q, st_d;
    logic     is_plain, is_rsv, is_xfr, is_pend;
    perm_t    perm_w;
    logic     cnt_done, cnt_excl, trans_done, trig;
    logic     snp_fire, dem_fire, req_fire;
    logic [NUM_PORTS-1:0] p_valid, p_stall, p_ready;

    logic          cnt_load, cnt_have;
    logic [CW-1:0] cnt_val;
    logic          gets_d, getx_d, getf_d, ldh_d, sth_d;

    coh_line_class u_class (
        .st       (st_q),
        .is_plain (is_plain),
        .is_rsv   (is_rsv),
        .is_xfr   (is_xfr),
        .is_pend  (is_pend),
        .perm     (perm_w)
    );

    coh_line_ackcnt #(.NUM_ACKS(NUM_ACKS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_cnt  (cnt_val),
        .load_have (cnt_have),
        .ack       (ack_in && is_pend),
        .fill      (fill_in && is_pend),
        .fill_excl (fill_excl),
        .all_done  (cnt_done),
        .excl      (cnt_excl)
    );

    // Internal events that take the cycle and block every port
    always_comb begin
        trans_done = is_pend && cnt_done;
        trig = trans_done || (xfer_done && is_xfr) || (xfer_start && is_plain);
    end

    // Port request and stall vectors in priority order
    always_comb begin
        p_valid[PORT_SNP] = snp_valid;
        p_valid[PORT_DEM] = dem_valid;
        p_valid[PORT_REQ] = req_valid;
        p_stall[PORT_SNP] = is_rsv || is_xfr;
        p_stall[PORT_DEM] = !is_plain;
        p_stall[PORT_REQ] = is_xfr || is_pend;
    end

    coh_line_arb #(.N(NUM_PORTS)) u_arb (
        .valid (p_valid),
        .stall (p_stall),
        .block (trig),
        .ready (p_ready)
    );

    // Handshake outputs and accepted transfers
    always_comb begin
        snp_ready = p_ready[PORT_SNP];
        dem_ready = p_ready[PORT_DEM];
        req_ready = p_ready[PORT_REQ];
        snp_fire  = snp_valid && snp_ready;
        dem_fire  = dem_valid && dem_ready;
        req_fire  = req_valid && req_ready;
    end

    // Next state, outbound strobes and counter loading
    always_comb begin
        st_d     = st_q;
        gets_d   = 1'b0;
        getx_d   = 1'b0;
        getf_d   = 1'b0;
        ldh_d    = 1'b0;
        sth_d    = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_have = 1'b0;
        if (trans_done) begin
            case (st_q)
                PND_RDS:                      st_d = cnt_excl ? LN_MOD : LN_SHR;
                PND_WR_I, PND_WR_S, PND_WR_O: st_d = LN_DRT;
                default:                      st_d = LN_INV;
            endcase
        end else if (xfer_done && is_xfr) begin
            st_d = to_rsv(st_q);
        end else if (xfer_start && is_plain) begin
            st_d = to_xfr(st_q);
        end else if (snp_fire) begin
            if (is_plain) begin
                case (snp_op)
                    SNP_EXCL, SNP_INV: st_d = LN_INV;
                    SNP_SHR, SNP_MRG, SNP_NOMIG:
                        if (st_q == LN_MOD || st_q == LN_DRT) st_d = LN_OWN;
                    default: st_d = st_q;
                endcase
            end
        end else if (dem_fire) begin
            st_d = st_q;
        end else if (req_fire) begin
            case (base_of(st_q))
                LN_INV: begin
                    cnt_load = 1'b1;
                    case (req_op)
                        OP_STORE: begin
                            st_d = PND_WR_I; getx_d = 1'b1; cnt_val = CNT_FULL;
                        end
                        OP_FLUSH: begin
                            st_d = PND_FL_I; getf_d = 1'b1; cnt_val = CNT_FULL;
                        end
                        default: begin
                            st_d = PND_RDS; gets_d = 1'b1;
                        end
                    endcase
                end
                LN_SHR: begin
                    case (req_op)
                        OP_STORE: begin
                            st_d = PND_WR_S; getx_d = 1'b1;
                            cnt_load = 1'b1; cnt_val = CNT_FULL; cnt_have = 1'b1;
                        end
                        OP_FLUSH: begin
                            st_d = PND_FL_S; getf_d = 1'b1;
                            cnt_load = 1'b1; cnt_val = CNT_FULL; cnt_have = 1'b1;
                        end
                        default: begin
                            st_d = LN_SHR; ldh_d = 1'b1;
                        end
                    endcase
                end
                LN_OWN: begin
                    case (req_op)
                        OP_STORE: begin
                            st_d = PND_WR_O; getx_d = 1'b1;
                            cnt_load = 1'b1; cnt_val = CNT_LESS; cnt_have = 1'b1;
                        end
                        OP_FLUSH: begin
                            st_d = PND_FL_O; getf_d = 1'b1;
                            cnt_load = 1'b1; cnt_val = CNT_LESS; cnt_have = 1'b1;
                        end
                        default: begin
                            st_d = LN_OWN; ldh_d = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (req_op)
                        OP_STORE: begin
                            st_d = LN_DRT; sth_d = 1'b1;
                        end
                        OP_FLUSH: begin
                            st_d = PND_FL_M; getf_d = 1'b1;
                            cnt_load = 1'b1; cnt_val = CNT_LESS; cnt_have = 1'b1;
                        end
                        default: begin
                            st_d = base_of(st_q); ldh_d = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

    // Line state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LN_INV;
        else        st_q <= st_d;
    end

    // Registered single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gets   <= 1'b0;
            getx   <= 1'b0;
            getf   <= 1'b0;
            ld_hit <= 1'b0;
            st_hit <= 1'b0;
        end else begin
            gets   <= gets_d;
            getx   <= getx_d;
            getf   <= getf_d;
            ld_hit <= ldh_d;
            st_hit <= sth_d;
        end
    end

    // Permission of the current state
    always_comb perm = perm_w;

endmodule

// File: rtl/coh_line_chk.sv
// Protocol checker for the coherence line controller, bound to every
// instance. Observes the state register and the ports; drives nothing.
module coh_line_chk
    import coh_line_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input line_st_t   st,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ready,
    input logic       snp_valid,
    input logic       snp_ready,
    input logic       dem_ready,
    input logic       xfer_done,
    input logic       gets,
    input logic       getx,
    input logic       getf,
    input logic       ld_hit,
    input logic       st_hit,
    input logic [1:0] perm
);

    logic in_rsv, in_xfr, in_pend;

    // State group decode local to the checker
    always_comb begin
        in_rsv  = st inside {RSV_INV, RSV_SHR, RSV_OWN, RSV_MOD, RSV_DRT};
        in_xfr  = st inside {XFR_INV, XFR_SHR, XFR_OWN, XFR_MOD, XFR_DRT};
        in_pend = st inside {PND_RDS, PND_WR_I, PND_WR_S, PND_WR_O,
                             PND_FL_I, PND_FL_S, PND_FL_O, PND_FL_M};
    end

    AST_XFR_TO_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XFR_SHR && xfer_done) |=> (st == RSV_SHR)); // R1
    AST_RSV_DRT_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSV_DRT) |-> (perm == 2'd2)); // R2
    AST_RSV_RD_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {RSV_SHR, RSV_OWN, RSV_MOD}) |-> (perm == 2'd1)); // R2
    AST_RSV_SNP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_rsv |-> !snp_ready); // R3
    AST_XFR_ALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_xfr |-> (!snp_ready && !req_ready && !dem_ready)); // R4
    AST_DEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rsv || in_pend) |-> !dem_ready); // R5
    AST_RSV_LOAD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSV_SHR && req_valid && req_ready && !req_op[1])
        |=> (st == LN_SHR && ld_hit)); // R6
    AST_RSV_STORE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {RSV_MOD, RSV_DRT} && req_valid && req_ready && req_op == 2'd2)
        |=> (st == LN_DRT && st_hit)); // R7
    AST_ONE_GET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gets, getx, getf})); // R8
    AST_SNP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready) |-> (!req_ready && !dem_ready)); // R10

endmodule

bind coh_line_ctrl coh_line_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .snp_valid (snp_valid),
    .snp_ready (snp_ready),
    .dem_ready (dem_ready),
    .xfer_done (xfer_done),
    .gets      (gets),
    .getx      (getx),
    .getf      (getf),
    .ld_hit    (ld_hit),
    .st_hit    (st_hit),
    .perm      (perm)
);

// File: tb/coh_line_ctrl_test.sv
// Directed bench for the coherence line controller. Inputs change just
// after a falling edge; outputs are sampled before the next rising edge.
module coh_line_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_ACK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_ready;
    logic       snp_valid = 1'b0;
    logic [2:0] snp_op = 3'd0;
    logic       snp_ready;
    logic       xfer_start = 1'b0;
    logic       xfer_done = 1'b0;
    logic       dem_valid = 1'b0;
    logic       dem_ready;
    logic       ack_in = 1'b0;
    logic       fill_in = 1'b0;
    logic       fill_excl = 1'b0;
    logic       gets, getx, getf, ld_hit, st_hit;
    logic [1:0] perm;

    int total = 0;
    int bad = 0;
    int snp_taken = 0;
    int snp_expect = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coh_line_ctrl #(.NUM_ACKS(N_ACK)) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_op (req_op), .req_ready (req_ready),
        .snp_valid (snp_valid), .snp_op (snp_op), .snp_ready (snp_ready),
        .xfer_start (xfer_start), .xfer_done (xfer_done),
        .dem_valid (dem_valid), .dem_ready (dem_ready),
        .ack_in (ack_in), .fill_in (fill_in), .fill_excl (fill_excl),
        .gets (gets), .getx (getx), .getf (getf),
        .ld_hit (ld_hit), .st_hit (st_hit), .perm (perm)
    );

    // Count snoop handshakes at the edge
    always @(posedge clk) if (rst_n && snp_valid && snp_ready) snp_taken++;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic xfer_in();
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        xfer_done = 1'b1;  tick(); xfer_done = 1'b0;
    endtask

    task automatic lreq(input logic [1:0] op, input string rq);
        req_valid = 1'b1; req_op = op;
        #1 chk(rq, "req_ready", int'(req_ready), 1);
        tick(); req_valid = 1'b0;
    endtask

    task automatic acks(input int n);
        for (int i = 0; i < n; i++) begin
            ack_in = 1'b1; tick(); ack_in = 1'b0;
        end
    endtask

    task automatic fill(input logic ex);
        fill_in = 1'b1; fill_excl = ex; tick(); fill_in = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R13", "perm", int'(perm), 0);
        chk("R13", "strobes", int'({gets, getx, getf, ld_hit, st_hit}), 0);
        chk("R13", "snp_ready", int'(snp_ready), 1);
        chk("R13", "req_ready", int'(req_ready), 1);
    endtask

    task automatic t_xfer_idle();
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        chk("R1", "perm transfer", int'(perm), 3);
        snp_valid = 1'b1; snp_op = 3'd1; req_valid = 1'b1; req_op = 2'd3; dem_valid = 1'b1;
        for (int i = 0; i < 2; i++) begin
            #1;
            chk("R4", "snp_ready", int'(snp_ready), 0);
            chk("R4", "flush ready", int'(req_ready), 0);
            chk("R4", "dem_ready", int'(dem_ready), 0);
            tick();
        end
        snp_valid = 1'b0; req_valid = 1'b0; dem_valid = 1'b0;
        chk("R4", "snoops taken", snp_taken, snp_expect);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R2", "perm reserved idle", int'(perm), 0);
        dem_valid = 1'b1;
        #1 chk("R5", "dem_ready reserved", int'(dem_ready), 0);
        tick(); dem_valid = 1'b0;
        lreq(2'd3, "R8");
        chk("R8", "getf", int'(getf), 1);
        chk("R8", "perm flush pending", int'(perm), 3);
        tick();
        chk("R8", "getf one cycle", int'(getf), 0);
        acks(N_ACK); fill(1'b0);
        chk("R8", "flush ends idle", int'(perm), 0);
    endtask

    task automatic t_idle_load();
        xfer_in();
        lreq(2'd0, "R8");
        chk("R8", "gets", int'(gets), 1);
        chk("R8", "perm read pending", int'(perm), 3);
        snp_valid = 1'b1; snp_op = 3'd4;
        #1 chk("R12", "snp_ready pending", int'(snp_ready), 1);
        tick(); snp_valid = 1'b0; snp_expect++;
        chk("R12", "pending unchanged", int'(perm), 3);
        fill(1'b1);
        chk("R8", "exclusive fill to M", int'(perm), 1);
    endtask

    task automatic t_rsv_mod();
        xfer_in();
        chk("R2", "perm reserved M", int'(perm), 1);
        lreq(2'd0, "R6");
        chk("R6", "ld_hit rsv M", int'(ld_hit), 1);
        chk("R6", "perm M", int'(perm), 1);
        xfer_in();
        lreq(2'd2, "R7");
        chk("R7", "st_hit rsv M", int'(st_hit), 1);
        chk("R7", "perm dirty", int'(perm), 2);
        xfer_in();
        chk("R2", "perm reserved dirty", int'(perm), 2);
        lreq(2'd1, "R6");
        chk("R6", "fetch hit rsv dirty", int'(ld_hit), 1);
        chk("R6", "perm dirty", int'(perm), 2);
        xfer_in();
        lreq(2'd2, "R7");
        chk("R7", "st_hit rsv dirty", int'(st_hit), 1);
        snp_valid = 1'b1; snp_op = 3'd1; tick(); snp_valid = 1'b0; snp_expect++;
        chk("R12", "shared snoop dirty to O", int'(perm), 1);
    endtask

    task automatic t_rsv_own();
        xfer_in();
        chk("R2", "perm reserved O", int'(perm), 1);
        lreq(2'd0, "R6");
        chk("R6", "ld_hit rsv O", int'(ld_hit), 1);
        xfer_in();
        snp_valid = 1'b1; snp_op = 3'd0;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R3", "snp held", int'(snp_ready), 0);
            tick();
        end
        chk("R3", "perm kept", int'(perm), 1);
        lreq(2'd2, "R10");
        chk("R9", "getx from O", int'(getx), 1);
        chk("R11", "held snoop not yet taken", snp_taken, snp_expect);
        #1 chk("R11", "snp_ready after release", int'(snp_ready), 1);
        tick(); snp_valid = 1'b0; snp_expect++;
        chk("R11", "snoop taken once", snp_taken, snp_expect);
        chk("R12", "pending unchanged by snoop", int'(perm), 1);
        acks(N_ACK - 2); tick();
        chk("R9", "not done early", int'(perm), 1);
        acks(1); tick();
        chk("R9", "upgrade done", int'(perm), 2);
    endtask

    task automatic t_rsv_shr_hold();
        lreq(2'd3, "R8");
        chk("R8", "getf from dirty", int'(getf), 1);
        acks(N_ACK - 1); tick();
        chk("R8", "flush to idle", int'(perm), 0);
        lreq(2'd0, "R8");
        fill(1'b0);
        chk("R8", "shared fill", int'(perm), 1);
        xfer_in();
        snp_valid = 1'b1; snp_op = 3'd5; dem_valid = 1'b1;
        #1;
        chk("R3", "snp held", int'(snp_ready), 0);
        chk("R5", "dem held reserved", int'(dem_ready), 0);
        chk("R10", "local served past held ports", int'(req_ready), 1);
        lreq(2'd0, "R6");
        chk("R6", "ld_hit rsv S", int'(ld_hit), 1);
        #1;
        chk("R11", "snp_ready after release", int'(snp_ready), 1);
        chk("R10", "snoop before demote", int'(dem_ready), 0);
        tick(); snp_valid = 1'b0; snp_expect++;
        chk("R12", "invalidate to idle", int'(perm), 0);
        #1 chk("R5", "dem_ready plain", int'(dem_ready), 1);
        tick(); dem_valid = 1'b0;
        chk("R5", "demote no change", int'(perm), 0);
        chk("R11", "snoop count", snp_taken, snp_expect);
    endtask

    task automatic t_rsv_shr_store();
        lreq(2'd0, "R8");
        fill(1'b0);
        xfer_in();
        lreq(2'd2, "R9");
        chk("R9", "getx from S", int'(getx), 1);
        acks(N_ACK - 1); tick();
        chk("R9", "waits for last ack", int'(perm), 1);
        acks(1); tick();
        chk("R9", "upgrade done", int'(perm), 2);
    endtask

    task automatic t_prio();
        snp_valid = 1'b1; snp_op = 3'd4; req_valid = 1'b1; req_op = 2'd0;
        #1;
        chk("R10", "snoop first", int'(snp_ready), 1);
        chk("R10", "local waits", int'(req_ready), 0);
        tick(); snp_valid = 1'b0; snp_expect++;
        chk("R12", "dma read no change", int'(perm), 2);
        #1 chk("R10", "local now", int'(req_ready), 1);
        tick(); req_valid = 1'b0;
        chk("R6", "ld_hit dirty", int'(ld_hit), 1);
        snp_valid = 1'b1; snp_op = 3'd1; xfer_start = 1'b1;
        #1 chk("R10", "blocked by transfer start", int'(snp_ready), 0);
        tick(); xfer_start = 1'b0;
        #1 chk("R4", "snp held transfer", int'(snp_ready), 0);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        #1 chk("R3", "snp held reserved", int'(snp_ready), 0);
        lreq(2'd0, "R6");
        #1 chk("R11", "snp_ready after release", int'(snp_ready), 1);
        tick(); snp_valid = 1'b0; snp_expect++;
        chk("R12", "shared snoop dirty to O", int'(perm), 1);
        chk("R11", "snoop count final", snp_taken, snp_expect);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Scenario sequence
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_xfer_idle();
        t_idle_load();
        t_rsv_mod();
        t_rsv_own();
        t_rsv_shr_hold();
        t_rsv_shr_store();
        t_prio();
        tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule